// File: doc/BRIEF.md
# Tagged Receive Silo for a Multi-Line Serial Multiplexer

This block gathers received characters from every line of a serial multiplexer into one shared first-in first-out silo. Each line's deserializer signals a finished character with a one-cycle strobe, together with the character and its break, framing and parity indications. The silo stores one tagged entry for each accepted strobe. The tag holds the character, the number of the source line, and three error flags.

Software drains the silo through a receive buffer read port. The port always shows the oldest entry with a valid bit on top. A read strobe while the valid bit is set removes that entry, so software reads repeatedly until the valid bit comes back clear. Each line has a parameter word, written through a single parameter port that names the line in its low field. The word holds the character size, stop bits, parity, a baud code and a receiver enable. The parameters go back out to the deserializers. The block uses two of the fields itself: the receiver enable gates storage, and the character size masks the unused high bits.

A done flag shows that the silo holds data. An interrupt line follows it only while the receive interrupt enable input is high. A clear input empties the silo and puts every line back to receiver-disabled.

Top module: `rx_silo_mux`

## Requirements
- R1: `rbuf_o` is {valid[14], overrun[13], framing[12], parity[11], line[10:8], char[7:0]} for the oldest stored entry. When the silo is empty, `rbuf_o` is all zero.
- R2: A cycle with `rd_i` high and valid set removes the oldest entry, and the next entry shows on the following cycle. `rd_i` while the silo is empty changes nothing.
- R3: Entries leave in arrival order. When several lines strobe in the same cycle, they are stored in ascending line number.
- R4: A strobe with its break input high is stored with char 0 and the framing flag set, whatever the character input carries.
- R5: `rx_done_o` is high exactly while the silo holds an entry. `rx_irq_o` is high only when `rx_done_o` and `rie_i` are both high.
- R6: A cycle with `lpr_wr_i` high loads the line numbered by `lpr_data_i[2:0]` with fields csize[4:3] (0..3 = 5..8 bits), two-stop[5], parity-enable[6], odd-parity[7], baud code[11:8] (0..14 = 50, 75, 110, 134, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600) and receiver-enable[12]. The line's 10-bit slice of `line_cfg_o` then reads lpr_data_i[12:3], starting with the next cycle. Other lines keep their values.
- R7: A strobe on a line whose receiver-enable is clear stores nothing.
- R8: Stored character bits at and above the line's character size are zero.
- R9: The silo holds 64 entries. A character that arrives while the silo is full is dropped, and the next entry that is stored carries the overrun flag. Later entries do not carry it.
- R10: `clr_i` empties the silo and clears every line's parameter word, including its receiver-enable, by the next cycle.
- R11: After reset the silo is empty, all parameter words are zero, and `rx_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty silo and clear all line parameters |
| lpr_wr_i | input | 1 | Line parameter write strobe |
| lpr_data_i | input | 13 | Line parameter word with line number in bits 2:0 |
| rx_strobe_i | input | 8 | Character complete, one bit per line |
| rx_char_i | input | 64 | Received characters, 8 bits per line, line 0 lowest |
| rx_brk_i | input | 8 | Break received, per line |
| rx_ferr_i | input | 8 | Framing error, per line |
| rx_perr_i | input | 8 | Parity error, per line |
| rd_i | input | 1 | Read strobe, removes the shown entry |
| rie_i | input | 1 | Receive interrupt enable |
| rbuf_o | output | 15 | Oldest entry with valid bit |
| rx_done_o | output | 1 | Silo holds data |
| rx_irq_o | output | 1 | Receive interrupt |
| line_cfg_o | output | 80 | Parameter words, 10 bits per line, line 0 lowest |

## Verification
On every cycle the assertions check the invariants. The fill level stays within 64. The valid bit agrees with the done flag, and the interrupt never fires without both done and enable. A clear leaves the silo empty and every receiver disabled. An empty silo stays empty unless an enabled line strobes. An overrun flag only appears after the silo has been full. Other properties need the bench's scenarios, because they depend on the contents and order of entries. These are the ascending-line order of simultaneous arrivals, the substitution of a zero character on a break, the masking for the character size, and that the overrun flag lands on exactly the first entry stored after a drop.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  // Per-line parameter word; the packed order matches the parameter port
  // above the line-number field.
  typedef struct packed {
    logic       rx_en;     // receiver enable
    logic [3:0] baud;      // rate code 0..14
    logic       par_odd;   // odd parity select
    logic       par_en;    // parity enable
    logic       two_stop;  // two stop bits
    logic [1:0] csize;     // 0..3 -> 5..8 data bits
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);

endpackage

// File: rtl/rx_line_cfg.sv
module rx_line_cfg
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        wr_i,
  input  logic [LINE_W-1:0]           wr_line_i,
  input  line_cfg_t                   wr_cfg_i,
  output line_cfg_t [NUM_LINES-1:0]   cfg_o
);

  line_cfg_t [NUM_LINES-1:0] cfg_q, cfg_d;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    // Clear takes priority over a write in the same cycle.
    always_comb begin
      cfg_d[g] = cfg_q[g];
      if (clr_i)
        cfg_d[g] = '0;
      else if (wr_i && (wr_line_i == LINE_W'(g)))
        cfg_d[g] = wr_cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[g] <= '0;
      else
        cfg_q[g] <= cfg_d[g];
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int DEPTH  = 64,   // power of two
  parameter int W      = 14,
  parameter int NUM_WR = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic [NUM_WR-1:0]             wr_req_i,
  input  logic [NUM_WR-1:0][W-1:0]      wr_data_i,
  input  logic                          pop_i,
  output logic [NUM_WR-1:0]             acc_o,
  output logic [W-1:0]                  head_o,
  output logic [CNT_W-1:0]              fill_o
);

  logic [W-1:0]             mem [DEPTH];
  logic [PTR_W-1:0]         wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]         fill_q, fill_d;
  logic [CNT_W-1:0]         n_acc;
  logic [NUM_WR-1:0][PTR_W-1:0] slot;
  logic                     pop;

  // Requests are packed into consecutive slots, lowest index first, while
  // space remains; the fill level before this cycle's pop bounds the space.
  always_comb begin
    n_acc = '0;
    for (int i = 0; i < NUM_WR; i++) begin
      slot[i]  = wptr_q + n_acc[PTR_W-1:0];
      acc_o[i] = wr_req_i[i] && ((int'(fill_q) + int'(n_acc)) < DEPTH);
      if (acc_o[i])
        n_acc = n_acc + CNT_W'(1);
    end
  end

  assign pop = pop_i && (fill_q != '0);

  always_comb begin
    if (clr_i) begin
      fill_d = '0;
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      fill_d = fill_q + n_acc - CNT_W'(pop);
      wptr_d = wptr_q + n_acc[PTR_W-1:0];
      rptr_d = rptr_q + PTR_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      fill_q <= fill_d;
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  // Storage array carries no reset; only slots behind the pointers are read.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_WR; i++) begin
      if (acc_o[i] && !clr_i)
        mem[slot[i]] <= wr_data_i[i];
    end
  end

  assign head_o = mem[rptr_q];
  assign fill_o = fill_q;

endmodule

// File: rtl/rx_silo_mux.sv
module rx_silo_mux
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 64,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int LPR_W    = LINE_W + CFG_W,
  localparam int ENT_W    = 3 + LINE_W + DATA_W,
  localparam int RB_W     = ENT_W + 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          lpr_wr_i,
  input  logic [LPR_W-1:0]              lpr_data_i,
  input  logic [NUM_LINES-1:0]          rx_strobe_i,
  input  logic [NUM_LINES*DATA_W-1:0]   rx_char_i,
  input  logic [NUM_LINES-1:0]          rx_brk_i,
  input  logic [NUM_LINES-1:0]          rx_ferr_i,
  input  logic [NUM_LINES-1:0]          rx_perr_i,
  input  logic                          rd_i,
  input  logic                          rie_i,
  output logic [RB_W-1:0]               rbuf_o,
  output logic                          rx_done_o,
  output logic                          rx_irq_o,
  output logic [NUM_LINES*CFG_W-1:0]    line_cfg_o
);

  line_cfg_t [NUM_LINES-1:0]         cfg;
  logic [NUM_LINES-1:0]              rx_en_vec;
  logic [NUM_LINES-1:0]              want, acc;
  logic [NUM_LINES-1:0][ENT_W-1:0]   ent;
  logic [ENT_W-1:0]                  head;
  logic [CNT_W-1:0]                  silo_fill;
  logic                              ovr_q, ovr_d;
  logic                              first_found;
  logic                              any_store, any_drop;

  // Zeroes character bits at and above the configured size.
  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++)
      m[b] = (b < (5 + int'(code)));
    return m;
  endfunction

  rx_line_cfg #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .wr_i      (lpr_wr_i),
    .wr_line_i (lpr_data_i[LINE_W-1:0]),
    .wr_cfg_i  (line_cfg_t'(lpr_data_i[LPR_W-1:LINE_W])),
    .cfg_o     (cfg)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cfg_out
    assign rx_en_vec[g]                   = cfg[g].rx_en;
    assign line_cfg_o[g*CFG_W +: CFG_W]   = cfg[g];
  end

  // Entry build: break forces a zero character with framing set; the
  // pending overrun rides on the lowest line that stores this cycle.
  always_comb begin
    first_found = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      want[i] = rx_strobe_i[i] && rx_en_vec[i] && !clr_i;
      ent[i]  = {1'b0,
                 rx_ferr_i[i] | rx_brk_i[i],
                 rx_perr_i[i],
                 LINE_W'(i),
                 rx_brk_i[i] ? '0
                             : (rx_char_i[i*DATA_W +: DATA_W] & size_mask(cfg[i].csize))};
      if (want[i] && !first_found) begin
        ent[i][ENT_W-1] = ovr_q;
        first_found     = 1'b1;
      end
    end
  end

  rx_silo_fifo #(
    .DEPTH  (DEPTH),
    .W      (ENT_W),
    .NUM_WR (NUM_LINES)
  ) u_silo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .wr_req_i  (want),
    .wr_data_i (ent),
    .pop_i     (rd_i),
    .acc_o     (acc),
    .head_o    (head),
    .fill_o    (silo_fill)
  );

  assign any_store = |acc;
  assign any_drop  = |(want & ~acc);

  always_comb begin
    if (clr_i)
      ovr_d = 1'b0;
    else if (any_drop)
      ovr_d = 1'b1;
    else if (any_store)
      ovr_d = 1'b0;
    else
      ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else
      ovr_q <= ovr_d;
  end

  assign rx_done_o = (silo_fill != '0);
  assign rx_irq_o  = rx_done_o && rie_i;
  assign rbuf_o    = rx_done_o ? {1'b1, head} : '0;

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  parameter int RB_W      = 15,
  parameter int CNT_W     = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_i,
  input logic                  rie_i,
  input logic [NUM_LINES-1:0]  rx_strobe_i,
  input logic [NUM_LINES-1:0]  rx_en_vec,
  input logic [RB_W-1:0]       rbuf_o,
  input logic                  rx_done_o,
  input logic                  rx_irq_o,
  input logic [CNT_W-1:0]      silo_fill
);

  logic seen_full;
  logic en_hit;

  assign en_hit = |(rx_strobe_i & rx_en_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_full <= 1'b0;
    else if (clr_i)
      seen_full <= 1'b0;
    else if (int'(silo_fill) == DEPTH)
      seen_full <= 1'b1;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(silo_fill) <= DEPTH);                                           // R9

  AST_OVR_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_o[RB_W-1] && rbuf_o[RB_W-2]) |-> seen_full);                  // R9

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !rx_done_o);                                               // R10

  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (rx_en_vec == '0));                                        // R10

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done_o && !en_hit) |=> !rx_done_o);                             // R7

  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> (rx_done_o && rie_i));                                  // R5

  AST_VALID_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_o[RB_W-1] == rx_done_o);                                        // R1

endmodule

bind rx_silo_mux rx_silo_chk #(
  .NUM_LINES (NUM_LINES),
  .DEPTH     (DEPTH),
  .RB_W      (RB_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .rie_i       (rie_i),
  .rx_strobe_i (rx_strobe_i),
  .rx_en_vec   (rx_en_vec),
  .rbuf_o      (rbuf_o),
  .rx_done_o   (rx_done_o),
  .rx_irq_o    (rx_irq_o),
  .silo_fill   (silo_fill)
);

// File: tb/rx_silo_mux_test.sv
module rx_silo_mux_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 64;
  localparam int CFGW  = 10;
  localparam int LPRW  = 13;
  localparam int RBW   = 15;

  logic              clk, rst_n, clr_i, lpr_wr_i, rd_i, rie_i;
  logic [LPRW-1:0]   lpr_data_i;
  logic [N-1:0]      rx_strobe_i, rx_brk_i, rx_ferr_i, rx_perr_i;
  logic [N*DW-1:0]   rx_char_i;
  logic [RBW-1:0]    rbuf_o;
  logic              rx_done_o, rx_irq_o;
  logic [N*CFGW-1:0] line_cfg_o;

  rx_silo_mux uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .lpr_wr_i(lpr_wr_i),
    .lpr_data_i(lpr_data_i), .rx_strobe_i(rx_strobe_i), .rx_char_i(rx_char_i),
    .rx_brk_i(rx_brk_i), .rx_ferr_i(rx_ferr_i), .rx_perr_i(rx_perr_i),
    .rd_i(rd_i), .rie_i(rie_i), .rbuf_o(rbuf_o), .rx_done_o(rx_done_o),
    .rx_irq_o(rx_irq_o), .line_cfg_o(line_cfg_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard state
  logic [RBW-1:0] exp_q[$];
  bit             m_en [N];
  int             m_size [N];
  int             m_fill = 0;
  bit             m_ovr = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [RBW-1:0] mk(input bit ovr, input bit fe, input bit pe,
                                        input int line, input logic [7:0] ch);
    return {1'b1, ovr, fe, pe, 3'(line), ch};
  endfunction

  task automatic idle_inputs();
    clr_i = 0; lpr_wr_i = 0; lpr_data_i = '0; rd_i = 0; rie_i = 0;
    rx_strobe_i = '0; rx_char_i = '0; rx_brk_i = '0; rx_ferr_i = '0; rx_perr_i = '0;
  endtask

  // Driver: parameter write, one cycle
  task automatic set_line(input int line, input bit en, input logic [3:0] baud,
                          input bit podd, input bit pen, input bit stop2, input int sz);
    lpr_data_i = {en, baud, podd, pen, stop2, 2'(sz), 3'(line)};
    lpr_wr_i = 1;
    @(negedge clk);
    lpr_wr_i = 0;
    m_en[line] = en;
    m_size[line] = sz;
  endtask

  // Driver: fire the strobes set up in the input vectors for one cycle,
  // pushing the expected entries in ascending line order.
  task automatic fire();
    logic [7:0] ch;
    bit         dropped;
    dropped = 0;
    for (int i = 0; i < N; i++) begin
      if (rx_strobe_i[i] && m_en[i]) begin
        if (m_fill < DEPTH) begin
          ch = rx_brk_i[i] ? 8'h00
               : (rx_char_i[i*DW +: DW] & 8'((1 << (5 + m_size[i])) - 1));
          exp_q.push_back(mk(m_ovr, rx_ferr_i[i] | rx_brk_i[i], rx_perr_i[i], i, ch));
          m_ovr = 0;
          m_fill++;
        end else begin
          dropped = 1;
        end
      end
    end
    if (dropped) m_ovr = 1;
    @(negedge clk);
    rx_strobe_i = '0; rx_brk_i = '0; rx_ferr_i = '0; rx_perr_i = '0; rx_char_i = '0;
  endtask

  task automatic one(input int line, input logic [7:0] ch, input bit brk,
                     input bit fe, input bit pe);
    rx_strobe_i[line] = 1;
    rx_char_i[line*DW +: DW] = ch;
    rx_brk_i[line] = brk;
    rx_ferr_i[line] = fe;
    rx_perr_i[line] = pe;
    fire();
  endtask

  // Monitor: pop and compare while the design reports data
  task automatic monitor(input string req);
    logic [RBW-1:0] e;
    while (rx_done_o) begin
      if (exp_q.size() == 0) begin
        check(req, 32'(rbuf_o), 32'h0, "unexpected silo entry");
      end else begin
        e = exp_q.pop_front();
        check(req, 32'(rbuf_o), 32'(e), "silo head");
      end
      rd_i = 1;
      @(negedge clk);
      rd_i = 0;
    end
    check(req, 32'(exp_q.size()), 32'h0, "expected entries never delivered");
    check(req, 32'(rbuf_o), 32'h0, "empty read word");
    exp_q.delete();
    m_fill = 0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_size[i] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11: reset state
    check("R11", 32'(rx_done_o), 0, "done after reset");
    check("R11", 32'(rx_irq_o), 0, "irq after reset");
    check("R11", 32'(rbuf_o), 0, "read word after reset");
    check("R11", 32'(line_cfg_o[31:0]), 0, "params after reset (low)");
    check("R11", 32'(line_cfg_o[79:32]), 0, "params after reset (high)");

    // R7: all receivers disabled at start
    one(3, 8'h41, 0, 0, 0);
    check("R7", 32'(rx_done_o), 0, "char on disabled line stored");

    // R6: parameter write and readback through line_cfg_o
    set_line(3, 1, 4'd14, 1, 1, 1, 2);
    check("R6", 32'(line_cfg_o[3*CFGW +: CFGW]), 32'({1'b1, 4'd14, 1'b1, 1'b1, 1'b1, 2'd2}),
          "line 3 parameter slice");
    check("R6", 32'(line_cfg_o[2*CFGW +: CFGW]), 0, "neighbour line untouched");
    for (int i = 0; i < N; i++) set_line(i, 1, 4'd5, 0, 0, 0, 3);

    // R1, R2: single character
    one(2, 8'hA5, 0, 0, 0);
    monitor("R1");

    // R3: simultaneous strobes stored lowest line first, then later arrival
    rx_strobe_i = 8'b0110_0010;
    rx_char_i[5*DW +: DW] = 8'h55;
    rx_char_i[1*DW +: DW] = 8'h11;
    rx_char_i[6*DW +: DW] = 8'h66;
    fire();
    one(0, 8'h00, 0, 0, 0);
    monitor("R3");

    // R4: break gives zero char with framing flag
    one(4, 8'h7E, 1, 0, 0);
    // R1: parity and framing flags carried
    one(0, 8'h33, 0, 0, 1);
    one(1, 8'h44, 0, 1, 0);
    monitor("R4");

    // R8: character size masking
    set_line(7, 1, 4'd0, 0, 0, 0, 0);
    set_line(6, 1, 4'd0, 0, 0, 0, 1);
    one(7, 8'hFF, 0, 0, 0);
    one(6, 8'hFF, 0, 0, 0);
    monitor("R8");

    // R7: disabled line among enabled ones
    set_line(3, 0, 4'd5, 0, 0, 0, 3);
    rx_strobe_i = 8'b0000_1100;
    rx_char_i[3*DW +: DW] = 8'h33;
    rx_char_i[2*DW +: DW] = 8'h22;
    fire();
    monitor("R7");

    // R5: interrupt gating
    one(5, 8'h5A, 0, 0, 0);
    check("R5", 32'(rx_done_o), 1, "done with data");
    check("R5", 32'(rx_irq_o), 0, "irq with enable low");
    rie_i = 1;
    #1;
    check("R5", 32'(rx_irq_o), 1, "irq with enable high");
    monitor("R5");
    #1;
    check("R5", 32'(rx_irq_o), 0, "irq when empty");
    rie_i = 0;

    // R2: read on empty silo has no effect
    rd_i = 1;
    @(negedge clk);
    rd_i = 0;
    check("R2", 32'(rbuf_o), 0, "read word after empty read");
    one(1, 8'hC3, 0, 0, 0);
    monitor("R2");

    // R9: fill, overflow, overrun on next stored entry only
    for (int k = 0; k < DEPTH; k++) one(0, 8'(k), 0, 0, 0);
    check("R9", 32'(rx_done_o), 1, "silo full");
    one(2, 8'hEE, 0, 0, 0);
    monitor("R9");
    one(4, 8'h12, 0, 0, 0);
    one(4, 8'h13, 0, 0, 0);
    check("R9", 32'(rbuf_o), 32'(mk(1, 0, 0, 4, 8'h12)), "overrun on first entry after drop");
    monitor("R9");

    // R10: clear empties silo and disables receivers
    one(1, 8'h01, 0, 0, 0);
    one(2, 8'h02, 0, 0, 0);
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    exp_q.delete();
    m_fill = 0; m_ovr = 0;
    for (int i = 0; i < N; i++) m_en[i] = 0;
    check("R10", 32'(rx_done_o), 0, "done after clear");
    check("R10", 32'(line_cfg_o[31:0]), 0, "params after clear (low)");
    check("R10", 32'(line_cfg_o[79:32]), 0, "params after clear (high)");
    one(1, 8'h77, 0, 0, 0);
    check("R10", 32'(rx_done_o), 0, "char stored after clear");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule